// File: doc/BRIEF.md
# Timer Input Capture Channel

This block records a timestamp each time a qualifying edge arrives on one external input. The input is first passed through a clock synchronizer. An edge detector and a mode decoder then decide whether the edge counts. In the two prescaled modes only every 4th or every 16th rising edge counts. When an edge counts, the block takes the full count of one of two free-running time bases, chosen by a control bit. That value goes into a four-entry first-in first-out buffer.

Software sees a control/status byte and a buffer read port. Each read strobe removes the oldest entry. Two status bits show whether the buffer holds data and whether a capture was lost because the buffer was full. An interrupt pulse is raised after a programmable number of stored captures. Writing the control byte restarts the prescaler and the interrupt counter. Writing a disabled mode also empties the buffer and clears the lost-capture flag.

Top module: `capture_channel`

## Requirements
- R1: After reset the control/status byte reads 8'h00, the buffer is empty and `irq` is low.
- R2: Mode code 3'b011 (control bits 2:0) stores one timestamp per rising edge of `cap_pin` and none on a falling edge.
- R3: Mode code 3'b010 stores one timestamp per falling edge and none on a rising edge.
- R4: Mode code 3'b001 stores one timestamp on every edge of either polarity.
- R5: Mode code 3'b100 stores a timestamp only on every 4th rising edge counted from the last control write.
- R6: Mode code 3'b101 stores a timestamp only on every 16th rising edge counted from the last control write.
- R7: Control bit 7 chooses the time base: 0 stores `time_a`, 1 stores `time_b`.
- R8: The buffer holds up to 4 entries. `buf_rdata` shows the oldest entry, and a `buf_rd` strobe removes it. Status bit 3 is 1 exactly when the buffer holds at least one entry.
- R9: A capture that arrives when the buffer is full is discarded and sets status bit 4. Bit 4 stays set, including across writes of active modes, until a write selects a disabled mode. That write also empties the buffer.
- R10: `irq` is a one-cycle pulse each time the number of stored captures reaches N+1, where N is control bits 6:5.
- R11: Mode codes 3'b000, 3'b110 and 3'b111 are disabled and store nothing.
- R12: Any control write restarts the prescaler count and the interrupt capture count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| time_a | input | 16 | Time base 0 count |
| time_b | input | 16 | Time base 1 count |
| cap_pin | input | 1 | Asynchronous capture input |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control write data: bit 7 time base, 6:5 interrupt count, 2:0 mode |
| ctrl_rdata | output | 8 | Control byte with status: bit 4 overflow, bit 3 not-empty |
| buf_rd | input | 1 | Remove the oldest buffer entry |
| buf_rdata | output | 16 | Oldest buffer entry |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions assume that `cap_pin` is asynchronous but stays at each level for longer than the synchronizer depth. They also assume that `buf_rd` may be raised on an empty buffer with no effect, and that the time bases are free inputs whose value matters only in the cycle a capture fires. The stimulus holds every pin level for eight cycles and changes the time bases only while no edge is in flight. It changes the mode only while the pin is steady, so each expected timestamp is exactly the time base value set before the edge.

// File: rtl/cap_pkg.sv
package cap_pkg;
   localparam logic [2:0] MODE_OFF    = 3'b000;
   localparam logic [2:0] MODE_BOTH   = 3'b001;
   localparam logic [2:0] MODE_FALL   = 3'b010;
   localparam logic [2:0] MODE_RISE   = 3'b011;
   localparam logic [2:0] MODE_RISE_A = 3'b100;
   localparam logic [2:0] MODE_RISE_B = 3'b101;

   typedef struct packed {
      logic       tsel;
      logic [1:0] icnt;
      logic [2:0] mode;
   } cap_ctrl_t;

   function automatic logic mode_active(input logic [2:0] m);
      return (m != MODE_OFF) && (m <= MODE_RISE_B);
   endfunction
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cap_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~prev_q;
   assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cap_event.sv
module cap_event
   import cap_pkg::*;
#(
   parameter int RATIO_LO = 4,
   parameter int RATIO_HI = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rise,
   input  logic       fall,
   input  logic [2:0] mode,
   input  logic       restart,
   output logic       fire
);
   localparam int PW = $clog2(RATIO_HI);
   localparam logic [PW-1:0] LIM_LO = PW'(RATIO_LO - 1);
   localparam logic [PW-1:0] LIM_HI = PW'(RATIO_HI - 1);

   if (RATIO_LO < 2 || RATIO_HI <= RATIO_LO) begin : g_bad_ratio
      $error("cap_event: need 2 <= RATIO_LO < RATIO_HI");
   end

   logic [PW-1:0] pcnt_q;
   logic [PW-1:0] limit;
   logic          hit;

   always_comb begin
      hit   = 1'b0;
      limit = '0;
      case (mode)
         MODE_BOTH:   hit = rise | fall;
         MODE_FALL:   hit = fall;
         MODE_RISE:   hit = rise;
         MODE_RISE_A: begin hit = rise; limit = LIM_LO; end
         MODE_RISE_B: begin hit = rise; limit = LIM_HI; end
         default:     hit = 1'b0;
      endcase
   end

   assign fire = hit && (pcnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt_q <= '0;
      else if (restart) pcnt_q <= '0;
      else if (hit)     pcnt_q <= (pcnt_q == limit) ? '0 : pcnt_q + 1'b1;
   end

   // R5
   prescale_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_RISE_A) |-> (pcnt_q <= LIM_LO));
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("cap_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign rdata   = mem_q[rd_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + 1'b1;
         if (do_pop)  rd_q <= rd_q + 1'b1;
         cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wr_q] <= wdata;
   end

   // R8
   pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push && !flush) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/capture_channel.sv
module capture_channel
   import cap_pkg::*;
#(
   parameter int TW          = 16,
   parameter int DEPTH       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int RATIO_LO    = 4,
   parameter int RATIO_HI    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] time_a,
   input  logic [TW-1:0] time_b,
   input  logic          cap_pin,
   input  logic          ctrl_wr,
   input  logic [7:0]    ctrl_wdata,
   output logic [7:0]    ctrl_rdata,
   input  logic          buf_rd,
   output logic [TW-1:0] buf_rdata,
   output logic          irq
);
   if (DEPTH < 4) begin : g_bad_depth
      $error("capture_channel: interrupt field needs DEPTH >= 4");
   end

   cap_ctrl_t   ctrl_q;
   logic        ovf_q, irq_q;
   logic [1:0]  ev_q;
   logic        rise, fall, fire, full, empty;
   logic        flush, accept, lost;
   logic [TW-1:0] stamp;

   assign flush  = ctrl_wr && !mode_active(ctrl_wdata[2:0]);
   assign accept = fire && !full && !flush;
   assign lost   = fire && full && !flush;
   assign stamp  = ctrl_q.tsel ? time_b : time_a;

   cap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise(rise), .fall(fall));

   cap_event #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) u_event (
      .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
      .mode(ctrl_q.mode), .restart(ctrl_wr), .fire(fire));

   cap_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(accept), .pop(buf_rd),
      .wdata(stamp), .rdata(buf_rdata), .full(full), .empty(empty));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ovf_q  <= 1'b0;
         ev_q   <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= {ctrl_wdata[7], ctrl_wdata[6:5], ctrl_wdata[2:0]};
         if (flush)     ovf_q <= 1'b0;
         else if (lost) ovf_q <= 1'b1;
         if (ctrl_wr)     ev_q <= '0;
         else if (accept) ev_q <= (ev_q == ctrl_q.icnt) ? '0 : ev_q + 1'b1;
         irq_q <= !ctrl_wr && accept && (ev_q == ctrl_q.icnt);
      end
   end

   assign ctrl_rdata = {ctrl_q.tsel, ctrl_q.icnt, ovf_q, !empty, ctrl_q.mode};
   assign irq        = irq_q;

   // R9
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> $past(full));
   // R10
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(fire));
   // R11
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_active(ctrl_q.mode) |-> !fire);
   // R3
   fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.mode == MODE_FALL && fire) |-> fall);
endmodule

// File: tb/capture_channel_test.sv
module capture_channel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] time_a = '0, time_b = '0;
   logic        cap_pin = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic [7:0]  ctrl_wdata = '0;
   logic [7:0]  ctrl_rdata;
   logic        buf_rd = 1'b0;
   logic [15:0] buf_rdata;
   logic        irq;

   int checks = 0, errors = 0, irq_cnt = 0, irq_run = 0, irq_max = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   capture_channel uut (
      .clk(clk), .rst_n(rst_n), .time_a(time_a), .time_b(time_b),
      .cap_pin(cap_pin), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .ctrl_rdata(ctrl_rdata), .buf_rd(buf_rd), .buf_rdata(buf_rdata), .irq(irq));

   always @(posedge clk) begin
      if (irq) begin
         irq_cnt <= irq_cnt + 1;
         irq_run <= irq_run + 1;
         if (irq_run + 1 > irq_max) irq_max <= irq_run + 1;
      end else irq_run <= 0;
   end

   typedef struct packed {
      logic [2:0] mode;
      logic       tsel;
      logic       start;
      logic       hit;
   } vec_t;

   localparam vec_t VECS [11] = '{
      '{3'd3, 1'b0, 1'b0, 1'b1}, '{3'd3, 1'b0, 1'b1, 1'b0},
      '{3'd2, 1'b0, 1'b1, 1'b1}, '{3'd2, 1'b0, 1'b0, 1'b0},
      '{3'd1, 1'b0, 1'b0, 1'b1}, '{3'd1, 1'b0, 1'b1, 1'b1},
      '{3'd3, 1'b1, 1'b0, 1'b1}, '{3'd2, 1'b1, 1'b1, 1'b1},
      '{3'd0, 1'b0, 1'b0, 1'b0}, '{3'd6, 1'b0, 1'b0, 1'b0},
      '{3'd7, 1'b0, 1'b1, 1'b0}};

   function automatic string req_of(input logic [2:0] m, input logic ts);
      if (ts) return "R7";
      case (m)
         3'd3: return "R2";
         3'd2: return "R3";
         3'd1: return "R4";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_ctrl(input logic [7:0] v);
      @(negedge clk); ctrl_wdata = v; ctrl_wr = 1'b1;
      @(negedge clk); ctrl_wr = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic set_pin(input logic v);
      @(negedge clk); cap_pin = v;
      repeat (8) @(negedge clk);
   endtask

   task automatic pulse();
      set_pin(1'b1);
      set_pin(1'b0);
   endtask

   task automatic pop_check(input logic [15:0] exp, input string req);
      @(negedge clk);
      check(buf_rdata, exp, req);
      buf_rd = 1'b1;
      @(negedge clk); buf_rd = 1'b0;
   endtask

   task automatic pop_only();
      @(negedge clk); buf_rd = 1'b1;
      @(negedge clk); buf_rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(ctrl_rdata, 8'h00, "R1");
      check(irq, 0, "R1");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(ctrl_rdata, 8'h00, "R1");

      // Vector table: R2 R3 R4 R7 R11
      for (int i = 0; i < 11; i++) begin
         write_ctrl(8'h00);
         set_pin(VECS[i].start);
         write_ctrl({VECS[i].tsel, 4'b0000, VECS[i].mode});
         time_a = 16'h1000 + 16'(i);
         time_b = 16'h2000 + 16'(i);
         set_pin(~VECS[i].start);
         check(ctrl_rdata[3], VECS[i].hit, req_of(VECS[i].mode, VECS[i].tsel));
         if (VECS[i].hit)
            pop_check(VECS[i].tsel ? 16'h2000 + 16'(i) : 16'h1000 + 16'(i),
                      req_of(VECS[i].mode, VECS[i].tsel));
      end

      // R8 / R9 fill, overflow, order
      write_ctrl(8'h00);
      set_pin(1'b0);
      write_ctrl(8'h03);
      for (int k = 0; k < 4; k++) begin
         time_a = 16'h3000 + 16'(k);
         pulse();
      end
      check(ctrl_rdata[4], 0, "R9");
      time_a = 16'h3004;
      pulse();
      check(ctrl_rdata[4], 1, "R9");
      write_ctrl(8'h03);
      check(ctrl_rdata[4], 1, "R9");
      for (int k = 0; k < 4; k++) pop_check(16'h3000 + 16'(k), "R8");
      @(negedge clk);
      check(ctrl_rdata[3], 0, "R8");
      time_a = 16'h3010;
      pulse(); pulse();
      write_ctrl(8'h00);
      check(ctrl_rdata[4:3], 2'b00, "R9");

      // R10 interrupt every 3 captures
      write_ctrl(8'h43);
      @(negedge clk); irq_cnt = 0; irq_max = 0;
      for (int k = 0; k < 6; k++) begin pulse(); pop_only(); end
      check(irq_cnt, 2, "R10");
      check(irq_max, 1, "R10");

      // R5 every 4th rising edge
      write_ctrl(8'h00);
      write_ctrl(8'h04);
      time_a = 16'h4444;
      for (int k = 0; k < 3; k++) pulse();
      check(ctrl_rdata[3], 0, "R5");
      pulse();
      check(ctrl_rdata[3], 1, "R5");
      pop_check(16'h4444, "R5");

      // R6 every 16th rising edge
      write_ctrl(8'h00);
      write_ctrl(8'h05);
      time_a = 16'h1616;
      for (int k = 0; k < 15; k++) pulse();
      check(ctrl_rdata[3], 0, "R6");
      pulse();
      check(ctrl_rdata[3], 1, "R6");
      pop_check(16'h1616, "R6");

      // R12 prescaler restart on control write
      write_ctrl(8'h00);
      write_ctrl(8'h04);
      pulse(); pulse();
      write_ctrl(8'h04);
      for (int k = 0; k < 3; k++) pulse();
      check(ctrl_rdata[3], 0, "R12");
      pulse();
      check(ctrl_rdata[3], 1, "R12");

      // R12 interrupt counter restart on control write
      write_ctrl(8'h00);
      write_ctrl(8'h23);
      @(negedge clk); irq_cnt = 0;
      pulse(); pop_only();
      write_ctrl(8'h23);
      pulse(); pop_only();
      check(irq_cnt, 0, "R12");
      pulse(); pop_only();
      check(irq_cnt, 1, "R12");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule